// File: doc/BRIEF.md
# Chainable Serial Front End for a Four-Channel DAC

This block is the digital side of a four-channel, 8-bit digital-to-analog converter. A host writes 12-bit command words over a four-wire serial link made of an active-low select, a serial clock and a data line in each direction. Each word names a channel, a two-bit control code and a data byte. The block holds one input register and one output (DAC) register per channel. Input registers take new data. DAC registers, whose contents drive the converters through a parallel output, copy the input registers when an update is commanded.

The serial output is the bit that falls off the end of the shift register. This lets several devices share one select line in a chain. A word with a no-operation code leaves a device untouched, so a host can skip that device. The edge on which the output changes can be set by command, and each of the two phase commands also updates every DAC register. A level-sensitive load input makes the DAC registers follow the input registers. An asynchronous clear input zeroes both banks.

All logic runs on a fast system clock. Serial clock, select, data and load are synchronised and edge-detected on that clock.

Top module: `qdac_serial_front`

## Requirements
- R1: After reset every DAC output is 0, `sdo_o` is low and the output phase is falling-edge.
- R2: A word is 12 bits, sampled from `sdi_i` on each serial-clock rising edge while `csn_i` is low, and sent most significant bit first. Bits [11:10] give the channel, bits [9:8] the control code and bits [7:0] the data. The word is decoded when `csn_i` rises. Channel n appears on `dac_o[8n+7:8n]`.
- R3: Control code 01 writes the data to the addressed input register and leaves every DAC register unchanged.
- R4: Channel 00 with control code 10 copies every input register into its DAC register. The data bits are ignored.
- R5: Control code 11 writes the addressed input register and then copies all input registers into the DAC registers in the same update.
- R6: Control code 00 with any channel, and channel 01 with control code 10, change no register.
- R7: When `csn_i` rises after a bit count that is not 12, only the last 12 bits sampled are decoded.
- R8: Channel 11 with control code 10 selects rising-edge output phase. Channel 10 with control code 10 selects falling-edge phase. Both also copy all input registers into the DAC registers, and both ignore the data. The phase persists through the clear input and changes only by command or reset.
- R9: In rising-edge phase, `sdo_o` changes on a serial-clock rising edge to the bit sampled 12 rising edges earlier. In falling-edge phase, `sdo_o` changes on a serial-clock falling edge to that same bit, so the output lags the input by 12.5 serial clocks.
- R10: While `csn_i` is high, serial-clock activity changes neither `sdo_o` nor any register.
- R11: While `ldn_i` is low, every DAC register follows its input register, so a write to an input register appears at once on the matching output.
- R12: While `clrn_i` is low, all input and DAC registers are held at zero, the clear taking effect without waiting for a clock edge. A command decoded during that time is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| csn_i | input | 1 | Active-low select; its rising edge decodes the word |
| sdi_i | input | 1 | Serial data in |
| ldn_i | input | 1 | Active-low level load: DAC registers transparent while low |
| clrn_i | input | 1 | Active-low asynchronous clear of both register banks |
| sdo_o | output | 1 | Serial data out for chaining; always driven |
| dac_o | output | 32 | DAC registers, channel n at bits [8n+7:8n] |

## Verification
The in-line assertions watch, on every cycle, the local rules that follow a decoded command or a held level. No-operation and load-only words leave the DAC bank alone. Load-and-update and transparent load make the two banks equal one cycle later. A held clear keeps both banks at zero. The serial output moves only on the serial-clock edge its phase selects, and it holds while the device is deselected. What needs the bench's scenarios is end-to-end behaviour. This covers serial framing and bit order across the synchroniser, decoding of truncated or overlong frames, the exact 12 and 12.5 clock lag of the chain output, phase persistence across a clear, and skipping a device through a no-operation slot, all checked against a behavioural model on every quiet clock.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic {
    PH_FALL = 1'b0,
    PH_RISE = 1'b1
  } dout_phase_e;

  localparam int CTL_W = 2;

  localparam logic [CTL_W-1:0] CTL_IDLE     = 2'b00;
  localparam logic [CTL_W-1:0] CTL_LOAD     = 2'b01;
  localparam logic [CTL_W-1:0] CTL_SPECIAL  = 2'b10;
  localparam logic [CTL_W-1:0] CTL_LOAD_UPD = 2'b11;

endpackage

// File: rtl/qdac_rst_sync.sv
module qdac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign srst_n = stg_q[STAGES-1];

endmodule

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int             N       = 4,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  logic [STAGES-1:0][N-1:0] chain_q;
  logic [STAGES-1:0][N-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
  import qdac_pkg::*;
#(
  parameter int WW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          tap_en,
  input  logic          cs_act,
  input  logic          sdi,
  input  dout_phase_e   phase,
  output logic [WW-1:0] word_o,
  output logic          dout_o
);

  logic [WW-1:0] shreg_q, shreg_d;
  logic          ext_q, ext_d;
  logic          dout_q, dout_d;

  always_comb begin
    shreg_d = shreg_q;
    ext_d   = ext_q;
    if (shift_en) begin
      shreg_d = {shreg_q[WW-2:0], sdi};
      ext_d   = shreg_q[WW-1];
    end
  end

  always_comb begin
    dout_d = dout_q;
    if (phase == PH_RISE && shift_en) begin
      dout_d = shreg_q[WW-1];
    end else if (phase == PH_FALL && tap_en) begin
      dout_d = ext_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      ext_q   <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      ext_q   <= ext_d;
      dout_q  <= dout_d;
    end
  end

  assign word_o = shreg_q;
  assign dout_o = dout_q;

  // R10
  dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && $past(!cs_act)) |-> $stable(dout_q));

  // R9
  dout_rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RISE && $past(phase == PH_RISE) && !$stable(dout_q)) |-> $past(shift_en));

  // R9
  dout_fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FALL && $past(phase == PH_FALL) && !$stable(dout_q)) |-> $past(tap_en));

endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bank_rst_n,
  input  logic                          cmd_stb,
  input  logic [AW+CTL_W+DW-1:0]        word,
  input  logic                          ld_act,
  output dout_phase_e                   phase_o,
  output logic [(1<<AW)-1:0][DW-1:0]    dac_o
);

  localparam int NCH = 1 << AW;
  localparam int WW  = AW + CTL_W + DW;
  localparam logic [AW-1:0] ADDR_UPD     = '0;
  localparam logic [AW-1:0] ADDR_PH_FALL = AW'(NCH - 2);
  localparam logic [AW-1:0] ADDR_PH_RISE = AW'(NCH - 1);

  logic [AW-1:0]    addr;
  logic [CTL_W-1:0] ctl;
  logic [DW-1:0]    data;

  logic        wr_in;
  logic        upd_all;
  logic        ph_wr;
  dout_phase_e ph_val;
  dout_phase_e phase_q;

  logic [NCH-1:0][DW-1:0] in_q, in_d;
  logic [NCH-1:0][DW-1:0] dac_q, dac_d;

  assign addr = word[WW-1 -: AW];
  assign ctl  = word[DW +: CTL_W];
  assign data = word[DW-1:0];

  always_comb begin
    wr_in   = 1'b0;
    upd_all = 1'b0;
    ph_wr   = 1'b0;
    ph_val  = phase_q;
    if (cmd_stb) begin
      unique case (ctl)
        CTL_LOAD: begin
          wr_in = 1'b1;
        end
        CTL_LOAD_UPD: begin
          wr_in   = 1'b1;
          upd_all = 1'b1;
        end
        CTL_SPECIAL: begin
          if (addr == ADDR_UPD) begin
            upd_all = 1'b1;
          end else if (addr == ADDR_PH_FALL) begin
            upd_all = 1'b1;
            ph_wr   = 1'b1;
            ph_val  = PH_FALL;
          end else if (addr == ADDR_PH_RISE) begin
            upd_all = 1'b1;
            ph_wr   = 1'b1;
            ph_val  = PH_RISE;
          end
        end
        default: begin
        end
      endcase
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    assign in_d[ch]  = (wr_in && addr == AW'(ch)) ? data : in_q[ch];
    assign dac_d[ch] = (upd_all || ld_act) ? in_d[ch] : dac_q[ch];
  end

  always_ff @(posedge clk or negedge bank_rst_n) begin
    if (!bank_rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      in_q  <= in_d;
      dac_q <= dac_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FALL;
    end else if (ph_wr) begin
      phase_q <= ph_val;
    end
  end

  assign phase_o = phase_q;
  assign dac_o   = dac_q;

  // R3
  load_only_chk: assert property (@(posedge clk) disable iff (!bank_rst_n)
    (cmd_stb && ctl == CTL_LOAD && !ld_act) |=> $stable(dac_q));

  // R5
  load_upd_chk: assert property (@(posedge clk) disable iff (!bank_rst_n)
    (cmd_stb && ctl == CTL_LOAD_UPD) |=> (dac_q == in_q));

  // R6
  nop_hold_chk: assert property (@(posedge clk) disable iff (!bank_rst_n)
    (cmd_stb && ctl == CTL_IDLE && !ld_act) |=> ($stable(dac_q) && $stable(in_q)));

  // R8
  phase_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && ctl == CTL_SPECIAL && addr == ADDR_PH_RISE) |=> (phase_q == PH_RISE));

  // R11
  ld_transp_chk: assert property (@(posedge clk) disable iff (!bank_rst_n)
    ld_act |=> (dac_q == in_q));

  // R12
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_rst_n |-> (in_q == '0 && dac_q == '0));

endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
  import qdac_pkg::*;
#(
  parameter int AW          = 2,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk_i,
  input  logic                      csn_i,
  input  logic                      sdi_i,
  input  logic                      ldn_i,
  input  logic                      clrn_i,
  output logic                      sdo_o,
  output logic [(1<<AW)*DW-1:0]     dac_o
);

  localparam int NCH = 1 << AW;
  localparam int WW  = AW + CTL_W + DW;
  localparam int NIN = 4;
  localparam int B_SCLK = 0;
  localparam int B_CSN  = 1;
  localparam int B_SDI  = 2;
  localparam int B_LDN  = 3;
  localparam logic [NIN-1:0] IN_RST = 4'b1010;

  logic [NIN-1:0] pins_s;
  logic           sclk_prev_q, sclk_prev_d;
  logic           csn_prev_q, csn_prev_d;
  logic           sclk_rise, sclk_fall, csn_rise;
  logic           cs_act, ld_act;
  logic           bank_arst_n, bank_rst_n;
  logic [WW-1:0]  word;
  dout_phase_e    phase;
  logic [NCH-1:0][DW-1:0] dac_q;

  qdac_sync #(
    .N       (NIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IN_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({ldn_i, sdi_i, csn_i, sclk_i}),
    .sync_o  (pins_s)
  );

  assign bank_arst_n = rst_n & clrn_i;

  qdac_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_clr_sync (
    .clk    (clk),
    .arst_n (bank_arst_n),
    .srst_n (bank_rst_n)
  );

  always_comb begin
    sclk_prev_d = pins_s[B_SCLK];
    csn_prev_d  = pins_s[B_CSN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      csn_prev_q  <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_prev_d;
      csn_prev_q  <= csn_prev_d;
    end
  end

  assign cs_act    = ~pins_s[B_CSN];
  assign ld_act    = ~pins_s[B_LDN];
  assign sclk_rise = pins_s[B_SCLK] & ~sclk_prev_q;
  assign sclk_fall = ~pins_s[B_SCLK] & sclk_prev_q;
  assign csn_rise  = pins_s[B_CSN] & ~csn_prev_q;

  qdac_shifter #(
    .WW (WW)
  ) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sclk_rise & cs_act),
    .tap_en   (sclk_fall & cs_act),
    .cs_act   (cs_act),
    .sdi      (pins_s[B_SDI]),
    .phase    (phase),
    .word_o   (word),
    .dout_o   (sdo_o)
  );

  qdac_regs #(
    .AW (AW),
    .DW (DW)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_rst_n (bank_rst_n),
    .cmd_stb    (csn_rise),
    .word       (word),
    .ld_act     (ld_act),
    .phase_o    (phase),
    .dac_o      (dac_q)
  );

  assign dac_o = dac_q;

endmodule

// File: tb/qdac_serial_front_bench.sv
module qdac_serial_front_bench;

  localparam int HALF  = 8;
  localparam int QUIET = 6;

  logic        clk;
  logic        rst_n;
  logic        sclk, csn, sdi, ldn, clrn;
  logic        sdo;
  logic [31:0] dac;

  int checks;
  int errors;
  int quiet;
  bit run;
  bit done;
  string cur_req;

  int  m_in  [4];
  int  m_dac [4];
  bit  m_dout;
  bit  m_mode;
  bit  m_ext;
  bit  m_q [$];

  qdac_serial_front u_qdac_serial_front (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk),
    .csn_i  (csn),
    .sdi_i  (sdi),
    .ldn_i  (ldn),
    .clrn_i (clrn),
    .sdo_o  (sdo),
    .dac_o  (dac)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      quiet++;
      if (quiet >= QUIET) begin
        for (int ch = 0; ch < 4; ch++) begin
          check(cur_req, int'(dac[ch*8 +: 8]), m_dac[ch]);
        end
        check(cur_req, int'(sdo), int'(m_dout));
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] w(input int a, input int c, input int d);
    return {2'(a), 2'(c), 8'(d)};
  endfunction

  task automatic model_decode();
    int wd, a, c, d;
    wd = 0;
    foreach (m_q[i]) wd = (wd << 1) | int'(m_q[i]);
    a = (wd >> 10) & 3;
    c = (wd >> 8) & 3;
    d = wd & 255;
    if (clrn) begin
      if (c == 1) begin
        m_in[a] = d;
      end else if (c == 3) begin
        m_in[a] = d;
        for (int k = 0; k < 4; k++) m_dac[k] = m_in[k];
      end else if (c == 2 && a != 1) begin
        for (int k = 0; k < 4; k++) m_dac[k] = m_in[k];
        if (a == 2) m_mode = 1'b0;
        if (a == 3) m_mode = 1'b1;
      end
      if (!ldn) for (int k = 0; k < 4; k++) m_dac[k] = m_in[k];
    end
  endtask

  task automatic send(input logic [31:0] val, input int n);
    @(negedge clk);
    csn = 1'b0; quiet = 0;
    wt(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = val[i]; quiet = 0;
      wt(HALF);
      sclk = 1'b1; quiet = 0;
      m_ext = m_q.pop_front();
      m_q.push_back(sdi);
      if (m_mode) m_dout = m_ext;
      wt(HALF);
      sclk = 1'b0; quiet = 0;
      if (!m_mode) m_dout = m_ext;
      wt(HALF);
    end
    csn = 1'b1; quiet = 0;
    model_decode();
    wt(2 * HALF);
  endtask

  task automatic clear_pulse(input bit with_write);
    @(negedge clk);
    clrn = 1'b0; quiet = 0;
    for (int k = 0; k < 4; k++) begin m_in[k] = 0; m_dac[k] = 0; end
    wt(4);
    if (with_write) send({20'h0, w(0, 3, 8'hEE)}, 12);
    @(negedge clk);
    clrn = 1'b1; quiet = 0;
    wt(2 * HALF);
  endtask

  initial begin
    checks = 0; errors = 0; quiet = 0; run = 1'b0; done = 1'b0;
    cur_req = "R1";
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; sdi = 1'b0; ldn = 1'b1; clrn = 1'b1;
    for (int k = 0; k < 4; k++) begin m_in[k] = 0; m_dac[k] = 0; end
    m_dout = 1'b0; m_mode = 1'b0; m_ext = 1'b0;
    for (int k = 0; k < 12; k++) m_q.push_back(1'b0);
    wt(5);
    rst_n = 1'b1;
    wt(8);
    // R1: reset state
    check("R1", int'(dac), 0);
    check("R1", int'(sdo), 0);
    run = 1'b1;

    // R3: load input only, outputs unchanged
    cur_req = "R3";
    send({20'h0, w(2, 1, 8'hA5)}, 12);
    check("R3", int'(dac[23:16]), 0);

    // R4: update all, data ignored
    cur_req = "R4";
    send({20'h0, w(0, 2, 8'hFF)}, 12);
    check("R4", int'(dac[23:16]), 8'hA5);

    // R5: load and update
    cur_req = "R5";
    send({20'h0, w(1, 3, 8'h3C)}, 12);
    check("R5", int'(dac[15:8]), 8'h3C);

    // R6: idle codes and reserved special do nothing
    cur_req = "R6";
    send({20'h0, w(3, 1, 8'h77)}, 12);
    send({20'h0, w(3, 0, 8'h11)}, 12);
    send({20'h0, w(1, 2, 8'h22)}, 12);
    check("R6", int'(dac[31:24]), 0);
    send({20'h0, w(0, 2, 8'h00)}, 12);
    check("R6", int'(dac[31:24]), 8'h77);

    // R7: overlong frame keeps the last twelve bits
    cur_req = "R7";
    send({17'h0, 3'b101, w(0, 3, 8'h5A)}, 15);
    check("R7", int'(dac[7:0]), 8'h5A);
    // R2: field positions and MSB-first order on channel 0
    check("R2", int'(dac), 32'h77A53C5A);

    // R8: rising-phase command also updates all DACs
    cur_req = "R8";
    send({20'h0, w(2, 1, 8'h99)}, 12);
    send({20'h0, w(3, 2, 8'hC3)}, 12);
    check("R8", int'(dac[23:16]), 8'h99);

    // R9: 24-bit chain frame in rising phase, last slot NOP
    cur_req = "R9";
    send({8'h0, w(1, 1, 8'h42), w(0, 0, 8'h00)}, 24);
    send({8'h0, w(2, 3, 8'h81), w(0, 0, 8'hFF)}, 24);
    check("R9", int'(dac[15:8]), 8'h3C);

    // R12: clear, with a write lost during clear
    cur_req = "R12";
    clear_pulse(1'b1);
    check("R12", int'(dac), 0);

    // R8: rising phase survives the clear
    cur_req = "R8";
    send({8'h0, w(2, 1, 8'h5C), w(1, 1, 8'h1E)}, 24);

    // R9: back to falling phase and stream
    cur_req = "R9";
    send({20'h0, w(2, 2, 8'h00)}, 12);
    send({8'h0, w(3, 3, 8'hB7), w(0, 0, 8'h55)}, 24);
    send({19'h0, 1'b1, w(2, 1, 8'hD2)}, 13);

    // R10: serial clock with select high changes nothing
    cur_req = "R10";
    begin
      int d0, o0;
      d0 = int'(dac); o0 = int'(sdo);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); sdi = ~sdi; sclk = 1'b1; quiet = 0;
        wt(HALF);
        sclk = 1'b0; quiet = 0;
        wt(HALF);
      end
      wt(2 * HALF);
      check("R10", int'(dac), d0);
      check("R10", int'(sdo), o0);
    end

    // R11: transparent load
    cur_req = "R11";
    @(negedge clk);
    ldn = 1'b0; quiet = 0;
    for (int k = 0; k < 4; k++) m_dac[k] = m_in[k];
    wt(2 * HALF);
    send({20'h0, w(3, 1, 8'h6B)}, 12);
    check("R11", int'(dac[31:24]), 8'h6B);
    @(negedge clk);
    ldn = 1'b1; quiet = 0;
    wt(2 * HALF);
    send({20'h0, w(0, 1, 8'h0F)}, 12);
    check("R11", int'(dac[7:0]), 0);

    wt(20);
    run = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule